// File: doc/BRIEF.md
# Ring-Oscillator Entropy Collection Core

This core gathers raw randomness from one of several free-running oscillator inputs. Each input is a single bit. While collection runs, a programmable divider picks one raw sample every D clock cycles from the selected input. A von Neumann corrector removes bias from the samples. The corrected bits shift into a 192-bit holding register, which the host reads as six 32-bit words. Each word clears itself to zero when it is read, so a zero word means no fresh data.

Three health monitors check the stream: a run-length test on the corrected bits, a whole-block repeat test, and a corrector-stall test. A cycle watchdog flags a source that is too slow or stuck. Each cause has its own status bit. A mask decides which status bits raise the interrupt, and the host clears a bit by writing 1 to it.

The host drives a plain single-cycle register port. Writes are taken on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`, and an active `reg_rd` strobe applies the clear-on-read side effect at the following edge. A software reset holds the core in its reset state for a fixed number of cycles. During that time register writes are dropped, so the host can tell that the reset is complete once a written sample-count value reads back.

Top module: `rosc_entropy_core`

## Requirements
- R1: After reset the status reads 0, the mask (0x07) reads 0x1F, `irq` is 0, the sample count (0x02) reads 0 and every holding word reads 0.
- R2: While collecting, one raw sample is taken from `raw_src[sel]` (sel at 0x01) in every running cycle k whose index is a multiple of D (D at 0x02, k counted from 1 after the enable write). When D is 0, no samples are taken.
- R3: With debug bit 0 at 0x05 cleared, samples are grouped in pairs: the pair 0 then 1 yields a 0, the pair 1 then 0 yields a 1, and equal pairs yield nothing. With that bit set, every sample passes straight through.
- R4: Each corrected bit enters bit 0 of word 0, and the 192-bit register shifts toward word 5 (word i is at 0x10+i). When the 192nd bit arrives, status bit 0 is set at the same edge and collection stops.
- R5: Reading a holding word returns its value and leaves that word at zero.
- R6: When 32 consecutive corrected bits are equal, status bit 1 is set at the edge of the 32nd bit and collection stops.
- R7: When the watchdog limit L at 0x04 is non-zero and the block is not full after L running cycles, status bit 2 is set and collection stops. L = 0 disables the watchdog.
- R8: When a completed block equals the block completed before it, status bit 3 is set. The first block after reset is only stored.
- R9: When 64 consecutive pairs yield nothing, status bit 4 is set. Collection continues and the count starts again.
- R10: `irq` is the OR of the status bits whose mask bits are 0. Writing ones to 0x08 clears the matching status bits.
- R11: Writes to the source select, the sample count and the debug register are ignored while the enable register (0x00 bit 0) is 1. Writing 1 to the enable register (re)starts collection.
- R12: Writing 1 to 0x03 returns all registers to their reset values for 8 cycles, and writes in that window are ignored. After that, a written sample count reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_src | input | N_SRC | Raw oscillator bits, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies clear-on-read) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt, unmasked status present |

## Verification
Every status bit is registered. A sample taken in running cycle k therefore shows its effect (full block, run-length error, stall, or the watchdog at k = L) right after edge k. The bench holds the read strobe on the status register during each collection. It advances its own model once per clock edge and compares the status at the following falling edge, so every set bit is checked in its exact cycle. Read data is combinational and is sampled a few nanoseconds after the address is driven. The clear-on-read effect lands at the next rising edge and is checked with a second read.

// File: rtl/rec_pkg.sv
`timescale 1ns/1ps
package rec_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_EN   = 5'h00;
  localparam logic [ADDR_W-1:0] A_SEL  = 5'h01;
  localparam logic [ADDR_W-1:0] A_SMPL = 5'h02;
  localparam logic [ADDR_W-1:0] A_SRST = 5'h03;
  localparam logic [ADDR_W-1:0] A_WDOG = 5'h04;
  localparam logic [ADDR_W-1:0] A_DBG  = 5'h05;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h06;
  localparam logic [ADDR_W-1:0] A_MASK = 5'h07;
  localparam logic [ADDR_W-1:0] A_CLR  = 5'h08;
  localparam logic [ADDR_W-1:0] A_EHR  = 5'h10;
  localparam int NSTAT   = 5;
  localparam int ST_FULL = 0;
  localparam int ST_AC   = 1;
  localparam int ST_WD   = 2;
  localparam int ST_REP  = 3;
  localparam int ST_VN   = 4;
  typedef logic [NSTAT-1:0] stat_t;
endpackage

// File: rtl/rec_sampler.sv
`timescale 1ns/1ps
module rec_sampler #(
  parameter int N_SRC  = 4,
  parameter int SMPL_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [SMPL_W-1:0] div,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_SRC-1:0]  raw,
  output logic              tick,
  output logic              smp
);
  logic [SMPL_W-1:0] cnt;

  assign tick = run && (div != '0) && (cnt == div - SMPL_W'(1));
  assign smp  = raw[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= tick ? '0 : cnt + SMPL_W'(1);
  end
endmodule

// File: rtl/rec_vn.sv
`timescale 1ns/1ps
module rec_vn #(
  parameter int STALL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic smp,
  input  logic bypass,
  output logic bv,
  output logic bb,
  output logic stall_err
);
  localparam int SW = $clog2(STALL + 1);
  logic          half, half_v;
  logic [SW-1:0] idle;
  logic          pair_dead;

  always_comb begin
    bv = 1'b0;
    bb = smp;
    if (tick) begin
      if (bypass) bv = 1'b1;
      else if (half_v && (half != smp)) begin
        bv = 1'b1;
        bb = half;
      end
    end
  end

  assign pair_dead = tick && !bypass && half_v && (half == smp);
  assign stall_err = pair_dead && (idle == SW'(STALL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= 1'b0; half_v <= 1'b0; idle <= '0;
    end else if (clr) begin
      half_v <= 1'b0; idle <= '0;
    end else begin
      if (tick && !bypass) begin
        if (!half_v) begin half <= smp; half_v <= 1'b1; end
        else half_v <= 1'b0;
      end
      if (bv) idle <= '0;
      else if (pair_dead) idle <= stall_err ? '0 : idle + SW'(1);
    end
  end
endmodule

// File: rtl/rec_health.sv
`timescale 1ns/1ps
module rec_health #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bv,
  input  logic bb,
  output logic ac_err
);
  localparam int RW = $clog2(RUN + 1);
  logic          last;
  logic [RW-1:0] len;
  logic          same;

  assign same   = (len != '0) && (bb == last);
  assign ac_err = bv && same && (len == RW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last <= 1'b0; len <= '0;
    end else if (clr) begin
      len <= '0;
    end else if (bv) begin
      last <= bb;
      len  <= same ? len + RW'(1) : RW'(1);
    end
  end
endmodule

// File: rtl/rosc_entropy_core.sv
`timescale 1ns/1ps
module rosc_entropy_core
  import rec_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int SMPL_W    = 16,
  parameter int EHR_WORDS = 6,
  parameter int AC_RUN    = 32,
  parameter int VN_STALL  = 64,
  parameter int RST_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  raw_src,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int SEL_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int EHR_BITS = EHR_WORDS * 32;
  localparam int NB_W     = $clog2(EHR_BITS + 1);
  localparam int IDX_W    = (EHR_WORDS > 1) ? $clog2(EHR_WORDS) : 1;
  localparam int RC_W     = $clog2(RST_CYC + 1);

  logic                en_q, run_q, byp_q, have_prev;
  logic [SEL_W-1:0]    sel_q;
  logic [SMPL_W-1:0]   smpl_q;
  logic [31:0]         wd_lim_q, wd_cnt;
  stat_t               stat_q, mask_q, set_v, clr_v;
  logic [EHR_BITS-1:0] ehr_q, ehr_d, prev_q, blk_new;
  logic [NB_W-1:0]     nbits;
  logic [RC_W-1:0]     busy_cnt;
  logic [31:0]         ehr_w [EHR_WORDS];
  logic                busy, wr_ok, start, srst, clr_core;
  logic                tick, smp, bv, bb, bv_g, vn_err, ac_err, ac_g;
  logic                full_now, wd_hit, stop, is_ehr, rd_clr;
  logic [ADDR_W-1:0]   ew_off;
  logic [IDX_W-1:0]    ehr_idx;

  assign busy     = (busy_cnt != '0);
  assign wr_ok    = reg_wr && !busy;
  assign start    = wr_ok && (reg_addr == A_EN) && reg_wdata[0];
  assign srst     = wr_ok && (reg_addr == A_SRST) && reg_wdata[0];
  assign clr_core = start || srst || busy;

  assign ew_off  = reg_addr - A_EHR;
  assign is_ehr  = (reg_addr >= A_EHR) && (ew_off < ADDR_W'(EHR_WORDS));
  assign ehr_idx = ew_off[IDX_W-1:0];
  assign rd_clr  = reg_rd && is_ehr && !busy;

  rec_sampler #(.N_SRC(N_SRC), .SMPL_W(SMPL_W), .SEL_W(SEL_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .clr(clr_core), .run(run_q), .div(smpl_q),
    .sel(sel_q), .raw(raw_src), .tick(tick), .smp(smp));

  rec_vn #(.STALL(VN_STALL)) u_vn (
    .clk(clk), .rst_n(rst_n), .clr(clr_core), .tick(tick), .smp(smp),
    .bypass(byp_q), .bv(bv), .bb(bb), .stall_err(vn_err));

  rec_health #(.RUN(AC_RUN)) u_hl (
    .clk(clk), .rst_n(rst_n), .clr(clr_core), .bv(bv), .bb(bb), .ac_err(ac_err));

  assign bv_g     = bv && !clr_core;
  assign ac_g     = ac_err && bv_g;
  assign blk_new  = {ehr_q[EHR_BITS-2:0], bb};
  assign full_now = bv_g && (nbits == NB_W'(EHR_BITS - 1));
  assign wd_hit   = run_q && !clr_core && (wd_lim_q != '0) &&
                    (wd_cnt == wd_lim_q - 32'd1) && !full_now;
  assign stop     = full_now || ac_g || wd_hit;

  always_comb begin
    set_v          = '0;
    set_v[ST_FULL] = full_now;
    set_v[ST_AC]   = ac_g;
    set_v[ST_WD]   = wd_hit;
    set_v[ST_REP]  = full_now && have_prev && (blk_new == prev_q);
    set_v[ST_VN]   = vn_err && !clr_core;
    clr_v = (wr_ok && reg_addr == A_CLR) ? reg_wdata[NSTAT-1:0] : '0;
  end

  always_comb begin
    ehr_d = bv_g ? blk_new : ehr_q;
    for (int i = 0; i < EHR_WORDS; i++)
      if (rd_clr && ehr_idx == IDX_W'(i)) ehr_d[i*32 +: 32] = '0;
  end

  for (genvar g = 0; g < EHR_WORDS; g++) begin : g_word
    assign ehr_w[g] = ehr_q[g*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0; en_q <= 1'b0; run_q <= 1'b0; sel_q <= '0; smpl_q <= '0;
      wd_lim_q <= '0; byp_q <= 1'b0; stat_q <= '0; mask_q <= '1; ehr_q <= '0;
      prev_q <= '0; have_prev <= 1'b0; nbits <= '0; wd_cnt <= '0;
    end else if (srst || busy) begin
      busy_cnt <= srst ? RC_W'(RST_CYC) : busy_cnt - RC_W'(1);
      en_q <= 1'b0; run_q <= 1'b0; sel_q <= '0; smpl_q <= '0;
      wd_lim_q <= '0; byp_q <= 1'b0; stat_q <= '0; mask_q <= '1; ehr_q <= '0;
      prev_q <= '0; have_prev <= 1'b0; nbits <= '0; wd_cnt <= '0;
    end else begin
      if (wr_ok && reg_addr == A_EN) begin
        en_q  <= reg_wdata[0];
        run_q <= reg_wdata[0];
      end else if (stop) run_q <= 1'b0;
      if (!en_q && wr_ok) begin
        if (reg_addr == A_SEL)  sel_q  <= reg_wdata[SEL_W-1:0];
        if (reg_addr == A_SMPL) smpl_q <= reg_wdata[SMPL_W-1:0];
        if (reg_addr == A_DBG)  byp_q  <= reg_wdata[0];
      end
      if (wr_ok && reg_addr == A_WDOG) wd_lim_q <= reg_wdata;
      if (wr_ok && reg_addr == A_MASK) mask_q   <= reg_wdata[NSTAT-1:0];
      stat_q <= (stat_q & ~clr_v) | set_v;
      ehr_q  <= ehr_d;
      if (start || full_now) nbits <= '0;
      else if (bv_g)         nbits <= nbits + NB_W'(1);
      if (start)      wd_cnt <= '0;
      else if (run_q) wd_cnt <= wd_cnt + 32'd1;
      if (full_now) begin
        prev_q    <= blk_new;
        have_prev <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (is_ehr) reg_rdata = ehr_w[ehr_idx];
    else begin
      case (reg_addr)
        A_EN:    reg_rdata[0]            = en_q;
        A_SEL:   reg_rdata[SEL_W-1:0]    = sel_q;
        A_SMPL:  reg_rdata[SMPL_W-1:0]   = smpl_q;
        A_WDOG:  reg_rdata               = wd_lim_q;
        A_DBG:   reg_rdata[0]            = byp_q;
        A_STAT:  reg_rdata[NSTAT-1:0]    = stat_q;
        A_MASK:  reg_rdata[NSTAT-1:0]    = mask_q;
        default: reg_rdata               = '0;
      endcase
    end
  end

  assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/rec_checker.sv
`timescale 1ns/1ps
module rec_checker
  import rec_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int SMPL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              en_q,
  input logic              busy,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [SEL_W-1:0]  sel_q,
  input logic [SMPL_W-1:0] smpl_q,
  input stat_t             stat_q,
  input logic [31:0]       ehr_w0
);
  AST_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_FULL]) |-> !run_q); // R4
  AST_EHR_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !busy && !run_q && reg_addr == A_EHR) |=> (ehr_w0 == '0)); // R5
  AST_RUNLEN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_AC]) |-> !run_q); // R6
  AST_WDOG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_WD]) |-> !run_q); // R7
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !busy && reg_wr && reg_addr == A_SEL) |=> $stable(sel_q)); // R11
  AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (smpl_q == '0 && !run_q)); // R12
endmodule

bind rosc_entropy_core rec_checker #(.SEL_W(SEL_W), .SMPL_W(SMPL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .en_q(en_q), .busy(busy),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .sel_q(sel_q),
  .smpl_q(smpl_q), .stat_q(stat_q), .ehr_w0(ehr_w[0]));

// File: tb/test_rosc_entropy_core.sv
`timescale 1ns/1ps
module test_rosc_entropy_core;
  import rec_pkg::*;
  localparam int EB = 192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] raw_src = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #10 clk = ~clk;

  rosc_entropy_core i_rosc_entropy_core (
    .clk(clk), .rst_n(rst_n), .raw_src(raw_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  int n_chk = 0, n_bad = 0;
  bit m_run, m_half, m_hv, m_last, m_hp, c_byp;
  int m_idle, m_len, m_n, c_D, c_sel, c_L, mode;
  logic [EB-1:0] m_ehr = '0, m_prev = '0;
  logic [4:0] m_stat = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #2 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic cfg(input int sel, input int d, input bit byp, input int l);
    wr(A_EN, 0); wr(A_SEL, sel); wr(A_SMPL, d); wr(A_DBG, {31'b0, byp}); wr(A_WDOG, l);
    c_sel = sel; c_D = d; c_byp = byp; c_L = l;
  endtask

  task automatic model_step(input int k);
    bit emit = 0, b = 0, full = 0, ac = 0, s;
    if (!m_run) return;
    if (c_D != 0 && k % c_D == 0) begin
      s = raw_src[c_sel];
      if (c_byp) begin emit = 1; b = s; end
      else if (!m_hv) begin m_half = s; m_hv = 1; end
      else begin
        m_hv = 0;
        if (m_half != s) begin emit = 1; b = m_half; end
        else begin
          m_idle++;
          if (m_idle == 64) begin m_stat[4] = 1; m_idle = 0; end
        end
      end
    end
    if (emit) begin
      m_idle = 0;
      m_ehr = {m_ehr[EB-2:0], b};
      m_n++;
      if (m_len != 0 && b == m_last) m_len++; else m_len = 1;
      m_last = b;
      if (m_len == 32) begin ac = 1; m_stat[1] = 1; end
      if (m_n == EB) begin
        full = 1; m_stat[0] = 1;
        if (m_hp && m_ehr == m_prev) m_stat[3] = 1;
        m_prev = m_ehr; m_hp = 1; m_n = 0;
      end
    end
    if (c_L != 0 && k == c_L && !full) m_stat[2] = 1;
    if (full || ac || (c_L != 0 && k == c_L)) m_run = 0;
  endtask

  // runs one collection; status compared every cycle against the model
  task automatic collect(input string tag, input int max);
    bit bad = 0; int tail = 0;
    logic [31:0] fa = '0, fe = '0;
    m_run = 1; m_hv = 0; m_idle = 0; m_len = 0; m_n = 0;
    wr(A_EN, 1);
    reg_rd = 1'b1; reg_addr = A_STAT;
    for (int k = 1; k <= max; k++) begin
      @(negedge clk);
      if (k > 1 && reg_rdata[4:0] !== m_stat && !bad) begin
        bad = 1; fa = reg_rdata; fe = {27'b0, m_stat};
      end
      if (!m_run) begin tail++; if (tail > 8) break; end
      case (mode)
        0: raw_src = 4'($urandom);
        1: raw_src = {4{k[0]}};
        default: raw_src = 4'b0;
      endcase
      @(posedge clk);
      model_step(k);
    end
    reg_rd = 1'b0;
    if (bad) chk(tag, fa, fe); else chk(tag, 0, 0);
  endtask

  task automatic check_words(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      rd(5'(A_EHR + i), v);
      chk(tag, v, m_ehr[i*32 +: 32]);
      m_ehr[i*32 +: 32] = '0;
    end
  endtask

  task automatic clear_status();
    wr(A_CLR, 32'h1F); m_stat = '0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 32'h1F);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_SMPL, v);  chk("R1 sample count", v, 0);
    rd(A_EHR, v);   chk("R1 ehr word0", v, 0);

    // R2 R3 R4 random source, corrector on
    mode = 0; cfg(2, 3, 0, 0);
    rd(A_SMPL, v); chk("R2 sample count write", v, 3);
    collect("R2 R3 R4 status timing", 20000);
    rd(A_STAT, v); chk("R4 full status", v, 32'h01);
    check_words("R3 R4 ehr word");
    rd(A_EHR, v); chk("R5 clear on read", v, 0);
    rd(5'(A_EHR + 5), v); chk("R5 clear on read word5", v, 0);

    // R11 config lock while enabled
    wr(A_SEL, 1); rd(A_SEL, v); chk("R11 sel locked", v, 2);
    wr(A_SMPL, 9); rd(A_SMPL, v); chk("R11 count locked", v, 3);
    wr(A_EN, 0); wr(A_SEL, 1); rd(A_SEL, v); chk("R11 sel after disable", v, 1);
    clear_status(); rd(A_STAT, v); chk("R10 clear all", v, 0);

    // R8 repeated block (bypass, alternating source)
    mode = 1; cfg(0, 1, 1, 0);
    collect("R3 R8 first block", 1000);
    rd(A_STAT, v); chk("R8 first block no repeat", v, 32'h01);
    clear_status();
    collect("R8 second block", 1000);
    rd(A_STAT, v); chk("R8 repeat flagged", v, 32'h09);
    clear_status();

    // R6 run-length error (corrector on, alternating pairs give all ones)
    mode = 1; cfg(0, 1, 0, 0);
    collect("R6 status timing", 1000);
    rd(A_STAT, v); chk("R6 run-length flag", v, 32'h02);
    clear_status();

    // R9 R7 stall and watchdog (constant source)
    mode = 2; cfg(3, 1, 0, 200);
    collect("R7 R9 status timing", 1000);
    rd(A_STAT, v); chk("R7 R9 stall+watchdog", v, 32'h14);

    // R10 interrupt masking and clearing
    chk("R10 irq all masked", {31'b0, irq}, 0);
    wr(A_MASK, 32'h1B); #1 chk("R10 irq unmasked", {31'b0, irq}, 1);
    wr(A_CLR, 32'h04); m_stat[2] = 0; #1 chk("R10 irq after clear", {31'b0, irq}, 0);
    rd(A_STAT, v); chk("R10 status after clear", v, 32'h10);
    wr(A_MASK, 32'h1F); clear_status();

    // R2 divider zero: no samples, watchdog only
    mode = 0; cfg(1, 0, 0, 50);
    collect("R2 zero divider timing", 200);
    rd(A_STAT, v); chk("R2 R7 zero divider", v, 32'h04);
    clear_status();

    // random configurations
    for (int r = 0; r < 2; r++) begin
      mode = 0;
      cfg(int'($urandom_range(3, 0)), int'($urandom_range(4, 1)), 0, 0);
      collect("R2 R4 random cfg timing", 40000);
      rd(A_STAT, v); chk("R4 random cfg full", v, 32'h01);
      check_words("R3 R4 random cfg words");
      clear_status();
    end

    // R12 soft reset
    wr(A_MASK, 32'h00);
    wr(A_SRST, 1);
    wr(A_SMPL, 5); rd(A_SMPL, v); chk("R12 write ignored in reset", v, 0);
    rd(A_MASK, v); chk("R12 mask back to default", v, 32'h1F);
    repeat (10) @(posedge clk);
    wr(A_SMPL, 5); rd(A_SMPL, v); chk("R12 readback after reset", v, 5);
    m_hp = 0; m_stat = '0; m_ehr = '0;
    rd(A_STAT, v); chk("R12 status after reset", v, 0);

    summary();
    $finish;
  end
endmodule